// File: doc/BRIEF.md
# Parallel Channel Service Request Arbiter

This block gathers service requests from the internal sources of a parallel peripheral channel. The sources are a control-state source (index 0) and a data-pipeline source (index 1). It signals the host through one active-low request line. The host can answer in either of two ways.

In the vectored path, the host runs a dedicated acknowledge bus cycle. The block answers that cycle with a vector byte that names the source being serviced. The external request then stays locked out until the host writes to an end-of-service register. In the polled path, software reads a summary register, a local vector register and a pending register. It then drops the request itself, either by writing zeros into the pending register or by toggling the enable bit.

All host traffic uses a plain register strobe interface. No data stream flows through the block, so it has no valid/ready handshake and no back-pressure: each register access and each acknowledge takes effect once, on the first clock edge of its strobe.

Top module: `svc_req_arbiter`

Register map (`addr`):
- 0: summary. Bit 3 is the any-pending bit; all other bits read 0.
- 1: live vector. Bits 2:0 hold the code of the current highest-priority pending source.
- 2: pending register, read/write. Bit 7 is the overall flag, bit 6 the control flag and bit 5 the pipeline flag.
- 3: control register. Bit 4 is the request enable.
- 4: end-of-service. Write only; the written data is ignored.
- 5: held vector. Read only.

Vector codes are 3'b001 for the control source, 3'b010 for the pipeline source and 3'b000 for no request. Bits 7:3 of a vector are always zero.

## Requirements
- R1: After reset `svc_req_n` is 1 and the summary, pending, control and held-vector registers all read 0x00.
- R2: A rising edge on a source input sets that source's flag and the overall flag on the next clock edge. With enable set and no lockout, `svc_req_n` then reads 0. It returns to 1 once every request has been serviced.
- R3: While enable (control bit 4) is 0, `svc_req_n` stays 1, even though source flags are still captured.
- R4: An acknowledge cycle is recognised only when `ack_n`, `grant_n` and `ds_n` are all 0 and `cs_n` is 1. With `cs_n` at 0 or `grant_n` at 1 the cycle is not an acknowledge: it sets no lockout and leaves the request asserted.
- R5: During an acknowledge cycle `rdata` carries the vector: 0x01 for the control source, 0x02 for the pipeline source and 0x00 for none. The control source wins when both are pending. Bits 7:3 are zero.
- R6: An acknowledge drives `svc_req_n` to 1 in the same cycle. It clears the serviced source's flag and locks the request out: new source edges raise no request until end-of-service.
- R7: The held vector reads the acknowledged code until an end-of-service write. Whatever data that write carries, it clears the held vector to 0x00 and ends the lockout, so a remaining or new flag raises the request again.
- R8: A read of the live vector register returns the code of the highest-priority pending source in bits 2:0, with bits 7:3 zero.
- R9: Summary bit 3 is 1 exactly when at least one source flag is set.
- R10: The pending register reads {overall, control, pipeline} in bits 7:5. A write clears each of those bits that is written as 0. Clearing bit 7 alone drops `svc_req_n` to 1 while the source flags stay readable.
- R11: A write that changes control bit 4 clears pending bits 7:5, the held vector and the lockout, and releases `svc_req_n`. A write of the unchanged value has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Register chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| grant_n | input | 1 | Bus grant, active low (used only by acknowledge) |
| ack_n | input | 1 | Service acknowledge, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or acknowledge vector, 0 when idle |
| src_req | input | 2 | Source request inputs, bit 0 control, bit 1 pipeline |
| svc_req_n | output | 1 | Service request to host, active low |

## Verification
The bench sweeps all four source patterns (none, control only, pipeline only, both) through the vectored path. This distinguishes wrong priority, a missing flag clear on acknowledge, and a request that re-arms before end-of-service. A source edge injected during the lockout, followed by a drain loop, shows that a later flag is reported only after end-of-service. Polled-path patterns cover several cases: clearing only the overall flag against clearing everything, a real toggle of the enable against an unchanged write, and near-miss acknowledge strobes with chip select low or grant high. Together they separate the two clearing mechanisms and the acknowledge decode from an ordinary read.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 3;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIVEVEC = 3'd1;
  localparam logic [ADDR_W-1:0] A_PENDING = 3'd2;
  localparam logic [ADDR_W-1:0] A_CONTROL = 3'd3;
  localparam logic [ADDR_W-1:0] A_EOS     = 3'd4;
  localparam logic [ADDR_W-1:0] A_HELDVEC = 3'd5;

  localparam int SUM_ANY_BIT = 3;
  localparam int CTL_EN_BIT  = 4;
  localparam int PEND_TOP    = 7;

  typedef enum logic [VEC_W-1:0] {
    VEC_NONE = 3'b000,
    VEC_CTL  = 3'b001,
    VEC_PIPE = 3'b010
  } vec_code_e;

  typedef struct packed {
    logic eos_wr;
    logic pend_wr;
    logic ctl_wr;
    logic rd_act;
    logic ack_act;
    logic ack_start;
  } bus_evt_t;
endpackage

// File: rtl/svc_bus_decode.sv
module svc_bus_decode
  import svc_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              grant_n,
  input  logic              ack_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_evt_t          evt
);
  logic sel, wr_act, wr_q, wr_fire, ack_act, ack_q;

  assign sel     = ~cs_n & ~ds_n;
  assign wr_act  = sel & ~rd_wr;
  assign ack_act = ~ack_n & ~grant_n & ~ds_n & cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      wr_q  <= wr_act;
      ack_q <= ack_act;
    end
  end

  assign wr_fire = wr_act & ~wr_q;

  always_comb begin
    evt           = '0;
    evt.rd_act    = sel & rd_wr;
    evt.ack_act   = ack_act;
    evt.ack_start = ack_act & ~ack_q;
    evt.eos_wr    = wr_fire & (addr == A_EOS);
    evt.pend_wr   = wr_fire & (addr == A_PENDING);
    evt.ctl_wr    = wr_fire & (addr == A_CONTROL);
  end
endmodule

// File: rtl/svc_src_capture.sv
module svc_src_capture #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               pend_wr,
  input  logic [NUM_SRC-1:0] keep,
  input  logic [NUM_SRC-1:0] ack_clr,
  input  logic               clr_all,
  output logic [NUM_SRC-1:0] flags,
  output logic               any_rise
);
  logic [NUM_SRC-1:0] src_q, rise;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign rise[i] = src_req[i] & ~src_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i] <= 1'b0;
        flags[i] <= 1'b0;
      end else begin
        src_q[i] <= src_req[i];
        if (clr_all)
          flags[i] <= 1'b0;
        else if (rise[i])
          flags[i] <= 1'b1;
        else if (ack_clr[i] || (pend_wr && !keep[i]))
          flags[i] <= 1'b0;
      end
    end
  end

  assign any_rise = |rise;
endmodule

// File: rtl/svc_vector_unit.sv
module svc_vector_unit
  import svc_arb_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags,
  input  logic               any_rise,
  input  bus_evt_t           evt,
  input  logic               en_wdata,
  input  logic               keep_top,
  output logic               ien,
  output logic               lock,
  output logic               pend_all,
  output logic               tog,
  output logic [VEC_W-1:0]   live_code,
  output logic [VEC_W-1:0]   hvec,
  output logic [NUM_SRC-1:0] ack_clr
);
  logic [NUM_SRC-1:0] iso;

  assign iso = flags & (~flags + 1'b1);

  always_comb begin
    live_code              = '0;
    live_code[NUM_SRC-1:0] = iso;
  end

  assign ack_clr = evt.ack_start ? iso : '0;
  assign tog     = evt.ctl_wr & (en_wdata != ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= 1'b0;
      lock     <= 1'b0;
      pend_all <= 1'b0;
      hvec     <= '0;
    end else begin
      if (evt.ctl_wr) ien <= en_wdata;

      if (tog || evt.eos_wr) begin
        lock <= 1'b0;
        hvec <= '0;
      end else if (evt.ack_start) begin
        lock <= 1'b1;
        hvec <= live_code;
      end

      if (tog)
        pend_all <= 1'b0;
      else if (any_rise)
        pend_all <= 1'b1;
      else if (evt.ack_start)
        pend_all <= |(flags & ~iso);
      else if (evt.pend_wr && !keep_top)
        pend_all <= 1'b0;
    end
  end
endmodule

// File: rtl/svc_req_arbiter.sv
module svc_req_arbiter
  import svc_arb_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              grant_n,
  input  logic              ack_n,
  input  logic              rd_wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [1:0]        src_req,
  output logic              svc_req_n
);
  bus_evt_t           evt;
  logic [NUM_SRC-1:0] flags, keep, ack_clr;
  logic               any_rise, ien, lock, pend_all, tog, ack_act, eos_fire;
  logic [VEC_W-1:0]   live_code, hvec;
  logic [DATA_W-1:0]  pend_rd;
  logic               unused_wbits;

  svc_bus_decode u_dec (
    .clk, .rst_n, .cs_n, .ds_n, .grant_n, .ack_n, .rd_wr, .addr, .evt
  );

  always_comb begin
    keep    = '0;
    pend_rd = '0;
    pend_rd[PEND_TOP] = pend_all;
    for (int i = 0; i < NUM_SRC; i++) begin
      keep[i] = wdata[PEND_TOP-1-i];
      pend_rd[PEND_TOP-1-i] = flags[i];
    end
  end

  svc_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk, .rst_n, .src_req(src_req[NUM_SRC-1:0]),
    .pend_wr(evt.pend_wr), .keep, .ack_clr, .clr_all(tog),
    .flags, .any_rise
  );

  svc_vector_unit #(.NUM_SRC(NUM_SRC)) u_vec (
    .clk, .rst_n, .flags, .any_rise, .evt,
    .en_wdata(wdata[CTL_EN_BIT]), .keep_top(wdata[PEND_TOP]),
    .ien, .lock, .pend_all, .tog, .live_code, .hvec, .ack_clr
  );

  assign ack_act      = evt.ack_act;
  assign eos_fire     = evt.eos_wr;
  assign unused_wbits = ^{wdata[3:0], wdata[CTL_EN_BIT-0+1]};
  assign svc_req_n    = ~(pend_all & ien & ~lock & ~ack_act);

  always_comb begin
    rdata = '0;
    if (ack_act) begin
      rdata[VEC_W-1:0] = lock ? hvec : live_code;
    end else if (evt.rd_act) begin
      case (addr)
        A_SUMMARY: rdata[SUM_ANY_BIT] = |flags;
        A_LIVEVEC: rdata[VEC_W-1:0]   = live_code;
        A_PENDING: rdata              = pend_rd;
        A_CONTROL: rdata[CTL_EN_BIT]  = ien;
        A_HELDVEC: rdata[VEC_W-1:0]   = hvec;
        default:   rdata              = '0;
      endcase
    end
  end
endmodule

// File: rtl/svc_arb_checker.sv
module svc_arb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_act,
  input logic       svc_req_n,
  input logic [7:0] rdata,
  input logic [2:0] hvec,
  input logic       lock,
  input logic       ien,
  input logic       eos_fire,
  input logic       tog,
  input logic       pend_all
);
  assert_ack_releases_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_act |-> svc_req_n);

  assert_lock_holds_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> svc_req_n);

  assert_vec_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_act |-> (rdata[7:3] == 5'd0));

  assert_vec_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hvec));

  assert_eos_clears_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eos_fire |=> (hvec == 3'd0 && !lock));

  assert_toggle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (!pend_all && hvec == 3'd0 && !lock));

  assert_req_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_req_n |-> ien);
endmodule

bind svc_req_arbiter svc_arb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ack_act(ack_act), .svc_req_n(svc_req_n),
  .rdata(rdata), .hvec(hvec), .lock(lock), .ien(ien),
  .eos_fire(eos_fire), .tog(tog), .pend_all(pend_all)
);

// File: tb/tb_svc_req_arbiter.sv
module tb_svc_req_arbiter;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, ds_n = 1'b1, grant_n = 1'b1, ack_n = 1'b1, rd_wr = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] src_req = '0;
  logic       svc_req_n;

  int checks = 0, fails = 0;
  bit mc, mp, mpa, mien, mlock;
  logic [7:0] mvec;

  svc_req_arbiter dut (
    .clk, .rst_n, .cs_n, .ds_n, .grant_n, .ack_n, .rd_wr, .addr,
    .wdata, .rdata, .src_req, .svc_req_n
  );

  always #2 clk = ~clk;

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired: got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] enc();
    return mc ? 8'h01 : (mp ? 8'h02 : 8'h00);
  endfunction

  function automatic logic exp_svc();
    return !(mpa && mien && !mlock);
  endfunction

  task automatic bus(input bit cs, input bit gr, input bit ak, input bit rw,
                     input logic [2:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic sv);
    @(negedge clk);
    cs_n = cs; ds_n = 1'b0; grant_n = gr; ack_n = ak; rd_wr = rw; addr = a; wdata = d;
    #1 rd = rdata; sv = svc_req_n;
    @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1; grant_n = 1'b1; ack_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; logic s;
    bus(1'b0, 1'b1, 1'b1, 1'b0, a, d, r, s);
    if (a == 3'd2) begin mc &= d[6]; mp &= d[5]; mpa &= d[7]; end
    if (a == 3'd4) begin mlock = 0; mvec = 0; end
    if (a == 3'd3) begin
      if (d[4] != mien) begin mc = 0; mp = 0; mpa = 0; mlock = 0; mvec = 0; end
      mien = d[4];
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] r; logic s;
    bus(1'b0, 1'b1, 1'b1, 1'b1, a, 8'h00, r, s);
    chk(req, r, exp);
  endtask

  task automatic ack_chk(input string req);
    logic [7:0] r; logic s; logic [7:0] v;
    v = enc();
    bus(1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00, r, s);
    chk(req, r, v);
    chk("R6 request released during acknowledge", {7'd0, s}, 8'h01);
    if (v == 8'h01) mc = 0; else if (v == 8'h02) mp = 0;
    mpa = mc | mp; mlock = 1; mvec = v;
  endtask

  task automatic pulse(input bit c, input bit p);
    @(negedge clk); src_req = {p, c};
    @(negedge clk); src_req = 2'b00;
    if (c) mc = 1;
    if (p) mp = 1;
    if (c || p) mpa = 1;
    #1;
  endtask

  task automatic svc_chk(input string req);
    #0 chk(req, {7'd0, svc_req_n}, {7'd0, exp_svc()});
  endtask

  initial begin
    logic [7:0] r; logic s;
    mc = 0; mp = 0; mpa = 0; mien = 0; mlock = 0; mvec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 svc_req_n after reset", {7'd0, svc_req_n}, 8'h01);
    rd_chk("R1 summary", 3'd0, 8'h00);
    rd_chk("R1 pending", 3'd2, 8'h00);
    rd_chk("R1 control", 3'd3, 8'h00);
    rd_chk("R1 held vector", 3'd5, 8'h00);

    // R3 disabled: flags captured, request held off
    pulse(1'b1, 1'b0);
    svc_chk("R3 no request while disabled");
    rd_chk("R9 summary while disabled", 3'd0, 8'h08);
    wr(3'd3, 8'h10);
    rd_chk("R11 enable toggle clears pending", 3'd2, 8'h00);
    svc_chk("R11 request idle after toggle");

    // Vectored path sweep over every source pattern
    for (int m = 0; m < 4; m++) begin
      wr(3'd2, 8'h00);
      wr(3'd4, 8'h00);
      pulse(m[0], m[1]);
      svc_chk("R2 request after source edge");
      rd_chk("R9 summary any-pending", 3'd0, (mc | mp) ? 8'h08 : 8'h00);
      rd_chk("R8 live vector", 3'd1, enc());
      rd_chk("R10 pending layout", 3'd2, {mpa, mc, mp, 5'd0});
      ack_chk("R5 acknowledge vector");
      pulse(1'b1, 1'b0);
      svc_chk("R6 lockout holds request");
      rd_chk("R7 held vector", 3'd5, mvec);
      wr(3'd4, 8'hA5);
      rd_chk("R7 held vector cleared", 3'd5, 8'h00);
      svc_chk("R7 request re-armed");
      for (int k = 0; k < 3 && (mc || mp); k++) begin
        ack_chk("R5 drain vector in priority order");
        wr(3'd4, 8'h5A);
        svc_chk("R7 request after drain step");
      end
      svc_chk("R2 request gone when drained");
    end

    // R10 clearing only the overall flag
    pulse(1'b1, 1'b1);
    svc_chk("R2 both sources");
    wr(3'd2, 8'h60);
    svc_chk("R10 overall clear drops request");
    rd_chk("R10 source flags kept", 3'd2, 8'h60);
    wr(3'd2, 8'h00);
    rd_chk("R10 full clear", 3'd2, 8'h00);

    // R11 unchanged enable write vs real toggle
    pulse(1'b0, 1'b1);
    wr(3'd3, 8'h10);
    svc_chk("R11 unchanged enable keeps request");
    rd_chk("R11 unchanged enable keeps flags", 3'd2, 8'hA0);
    wr(3'd3, 8'h00);
    svc_chk("R11 toggle releases request");
    rd_chk("R11 toggle clears flags", 3'd2, 8'h00);
    rd_chk("R11 control readback", 3'd3, 8'h00);
    wr(3'd3, 8'h10);

    // R4 near-miss acknowledge strobes
    pulse(1'b1, 1'b0);
    bus(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h00, r, s);
    chk("R4 chip select low gives a plain read", r, 8'h01);
    chk("R4 no release with chip select low", {7'd0, s}, 8'h00);
    bus(1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00, r, s);
    chk("R4 no vector without grant", r, 8'h00);
    svc_chk("R4 request still asserted");
    rd_chk("R4 no lockout taken", 3'd5, 8'h00);
    ack_chk("R5 genuine acknowledge");
    wr(3'd4, 8'h00);
    svc_chk("R2 released after service");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule